// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Core

This block is a synthesizable behavioural model of a static RAM with independent read and write data paths. Every access moves two words. Both start on the rising edge of one system clock, which stands in for the input clock: the rising edge acts as K and the falling edge acts as its complement. One address bus is shared by the two paths. It carries the read address at the rising edge and the write address at the following falling edge. An internal least significant bit is appended to that address, so word +0 and word +1 of a burst always go to or come from neighbouring locations, in that order.

Reads are returned with fixed latency. The output clock pair is modelled by the same two edges. Word +0 appears after the falling edge one cycle after the request, and word +1 appears after the next rising edge. A separate enable output marks the driven window; while it is low, the data bus is held at zero.

A write that has not yet reached the array is forwarded to a read of the same address. For each lane, the read returns the new data where the lane is enabled and the stored data elsewhere.

After reset, a lock timer holds the block busy, standing in for DLL lock time, and every request made in that period is dropped. The read path is a two-state machine:
- RD_NOP moves to RD_LOAD when a read is accepted.
- RD_LOAD stays in RD_LOAD on another accepted read and returns to RD_NOP otherwise.

The write path has the states WR_IDLE and WR_ARMED:
- An accepted write moves it to, or keeps it in, WR_ARMED.
- A slot with no write returns it to WR_IDLE.

Top module: `qdr_b2_sram`

## Requirements
- R1: After reset is released, `lock_busy` is high for exactly LOCK_CYCLES rising edges (1024 by default). It then stays low until the next reset.
- R2: A read request made while `lock_busy` is high produces no output: `rdata_oe` stays low and `rdata` stays zero.
- R3: A read accepted at rising edge t drives word +0 (location {addr,0}) after the falling edge of cycle t+1. It drives word +1 (location {addr,1}) after rising edge t+2. `rdata_oe` is high over both half-cycles.
- R4: A write takes word +0 from `wdata` at the rising edge where `wr_sel_n` is low. It takes word +1 and the write address from `addr` and `wdata` at the following falling edge.
- R5: `wr_lane_n[i]` (active low) enables bits [i*LANE_W +: LANE_W], which is bits 0-8 for lane 0 and bits 9-17 for lane 1 at the default size. The enables are sampled separately for each word, and a disabled lane keeps its stored bits.
- R6: A read and a write accepted on the same rising edge both complete, to and from independent addresses.
- R7: A read accepted on the same rising edge as a write to the same address returns the new write data in the enabled lanes and the old contents in the disabled lanes.
- R8: A read accepted one cycle after a write to the same address returns the written data.
- R9: When no read was accepted for a slot, `rdata_oe` is low and `rdata` is zero for both half-cycles of that slot. This is also the state during reset.
- R10: Cycles with neither request leave the array contents unchanged.
- R11: Reads accepted on consecutive rising edges keep `rdata_oe` high without a gap, each burst in request order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; the rising edge is K and the falling edge is its complement |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_sel_n | input | 1 | Read request, active low, sampled at the rising edge |
| wr_sel_n | input | 1 | Write request, active low, sampled at the rising edge |
| addr | input | ADDR_W | Read address at the rising edge, write address at the falling edge |
| wdata | input | LANES*LANE_W | Write word +0 at the rising edge, word +1 at the falling edge |
| wr_lane_n | input | LANES | Per-lane write enables, active low, sampled at each capture edge |
| rdata | output | LANES*LANE_W | Read data, word +0 while clk is low, word +1 while clk is high |
| rdata_oe | output | 1 | High while `rdata` carries a read word |
| lock_busy | output | 1 | High during the post-reset lock period |

## Verification
The hardest case to reach from the ports is the read that collides with a write still waiting for its array commit at the same address. A partial lane mask on one of its two words must make the merge visible. The stimulus reaches it by driving, within one clock period, a read and a write to the same address on the rising edge, then that same address with different data and mask on the falling edge. Masked lanes must already hold known data, so the merged word tells forwarded bits apart from stored ones. A behavioural model updates its array before it evaluates the read in the same slot, so every bench collision, random ones included, is predicted without mirroring the pipeline.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    typedef enum logic {
        RD_NOP,
        RD_LOAD
    } rd_state_t;

    typedef enum logic {
        WR_IDLE,
        WR_ARMED
    } wr_state_t;
endpackage

// File: rtl/qdr_lock_timer.sv
module qdr_lock_timer #(
    parameter int LOCK_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic lock_busy
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] DONE = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != DONE) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign lock_busy = (cnt != DONE);

    // R1
    busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_busy |=> !lock_busy);
endmodule

// File: rtl/qdr_store.sv
module qdr_store #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      wr_pend,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [LANES*LANE_W-1:0]   wr_word0,
    input  logic [LANES*LANE_W-1:0]   wr_word1,
    input  logic [LANES-1:0]          wr_en0,
    input  logic [LANES-1:0]          wr_en1,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [LANES*LANE_W-1:0]   rd_word0,
    output logic [LANES*LANE_W-1:0]   rd_word1
);
    localparam int WIDTH = LANES * LANE_W;
    localparam int DEPTH = 2 ** (ADDR_W + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             fwd_hit;

    assign fwd_hit = wr_pend && (wr_addr == rd_addr);

    // Commit the completed burst one rising edge after its capture.
    always_ff @(posedge clk) begin
        if (wr_pend) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_en0[l]) begin
                    mem[{wr_addr, 1'b0}][l*LANE_W +: LANE_W] <= wr_word0[l*LANE_W +: LANE_W];
                end
                if (wr_en1[l]) begin
                    mem[{wr_addr, 1'b1}][l*LANE_W +: LANE_W] <= wr_word1[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Lane-wise merge of the not-yet-committed burst into the read words.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_word0[l*LANE_W +: LANE_W] = (fwd_hit && wr_en0[l])
            ? wr_word0[l*LANE_W +: LANE_W]
            : mem[{rd_addr, 1'b0}][l*LANE_W +: LANE_W];
        assign rd_word1[l*LANE_W +: LANE_W] = (fwd_hit && wr_en1[l])
            ? wr_word1[l*LANE_W +: LANE_W]
            : mem[{rd_addr, 1'b1}][l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/qdr_wr_ctrl.sv
module qdr_wr_ctrl
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_busy,
    input  logic                    wr_sel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wr_lane_n,
    output logic                    wr_pend,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [LANES*LANE_W-1:0] wr_word0,
    output logic [LANES*LANE_W-1:0] wr_word1,
    output logic [LANES-1:0]        wr_en0,
    output logic [LANES-1:0]        wr_en1
);
    wr_state_t wr_state, wr_next;
    logic      wr_go;

    assign wr_go = !wr_sel_n && !lock_busy;

    always_comb begin
        unique case (wr_state)
            WR_IDLE:  wr_next = wr_go ? WR_ARMED : WR_IDLE;
            WR_ARMED: wr_next = wr_go ? WR_ARMED : WR_IDLE;
            default:  wr_next = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_state <= WR_IDLE;
        else        wr_state <= wr_next;
    end

    // Word +0 and its lane enables on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_word0 <= '0;
            wr_en0   <= '0;
        end else if (wr_go) begin
            wr_word0 <= wdata;
            wr_en0   <= ~wr_lane_n;
        end
    end

    // Address, word +1 and its lane enables on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_pend  <= 1'b0;
            wr_addr  <= '0;
            wr_word1 <= '0;
            wr_en1   <= '0;
        end else begin
            wr_pend <= (wr_state == WR_ARMED);
            if (wr_state == WR_ARMED) begin
                wr_addr  <= addr;
                wr_word1 <= wdata;
                wr_en1   <= ~wr_lane_n;
            end
        end
    end

    // R4
    wr_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_state == WR_ARMED) |-> wr_pend);

    // R2
    wr_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |-> !lock_busy);
endmodule

// File: rtl/qdr_rd_ctrl.sv
module qdr_rd_ctrl
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_busy,
    input  logic                    rd_sel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] rd_word0,
    input  logic [LANES*LANE_W-1:0] rd_word1,
    output logic [ADDR_W-1:0]       rd_addr_q,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int WIDTH = LANES * LANE_W;

    rd_state_t        rd_state, rd_next;
    logic             rd_go;
    logic             stg_vld, fall_oe, rise_oe;
    logic [WIDTH-1:0] stg0, stg1, hold1, fall_dat, rise_dat;

    assign rd_go = !rd_sel_n && !lock_busy;

    always_comb begin
        unique case (rd_state)
            RD_NOP:  rd_next = rd_go ? RD_LOAD : RD_NOP;
            RD_LOAD: rd_next = rd_go ? RD_LOAD : RD_NOP;
            default: rd_next = RD_NOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_state  <= RD_NOP;
            rd_addr_q <= '0;
        end else begin
            rd_state <= rd_next;
            if (rd_go) rd_addr_q <= addr;
        end
    end

    // Rising-edge output stages: array sample and word +1 launch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_vld  <= 1'b0;
            stg0     <= '0;
            stg1     <= '0;
            rise_oe  <= 1'b0;
            rise_dat <= '0;
        end else begin
            stg_vld <= (rd_state == RD_LOAD);
            if (rd_state == RD_LOAD) begin
                stg0 <= rd_word0;
                stg1 <= rd_word1;
            end
            rise_oe  <= fall_oe;
            rise_dat <= hold1;
        end
    end

    // Falling-edge output stage: word +0 launch, word +1 held.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_oe  <= 1'b0;
            fall_dat <= '0;
            hold1    <= '0;
        end else begin
            fall_oe  <= stg_vld;
            fall_dat <= stg0;
            hold1    <= stg1;
        end
    end

    assign rdata_oe = clk ? rise_oe : fall_oe;
    assign rdata    = rdata_oe ? (clk ? rise_dat : fall_dat) : '0;

    // R2
    rd_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == RD_LOAD) |-> !lock_busy);

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_oe |-> $past(rd_state == RD_LOAD, 2));
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
    parameter int ADDR_W      = 4,
    parameter int LANES       = 2,
    parameter int LANE_W      = 9,
    parameter int LOCK_CYCLES = 1024
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_sel_n,
    input  logic                    wr_sel_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [LANES-1:0]        wr_lane_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe,
    output logic                    lock_busy
);
    localparam int WIDTH = LANES * LANE_W;

    logic              wr_pend;
    logic [ADDR_W-1:0] wr_addr, rd_addr_q;
    logic [WIDTH-1:0]  wr_word0, wr_word1, rd_word0, rd_word1;
    logic [LANES-1:0]  wr_en0, wr_en1;

    qdr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_busy (lock_busy)
    );

    qdr_wr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_busy (lock_busy),
        .wr_sel_n  (wr_sel_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_lane_n (wr_lane_n),
        .wr_pend   (wr_pend),
        .wr_addr   (wr_addr),
        .wr_word0  (wr_word0),
        .wr_word1  (wr_word1),
        .wr_en0    (wr_en0),
        .wr_en1    (wr_en1)
    );

    qdr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .wr_pend  (wr_pend),
        .wr_addr  (wr_addr),
        .wr_word0 (wr_word0),
        .wr_word1 (wr_word1),
        .wr_en0   (wr_en0),
        .wr_en1   (wr_en1),
        .rd_addr  (rd_addr_q),
        .rd_word0 (rd_word0),
        .rd_word1 (rd_word1)
    );

    qdr_rd_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_busy (lock_busy),
        .rd_sel_n  (rd_sel_n),
        .addr      (addr),
        .rd_word0  (rd_word0),
        .rd_word1  (rd_word1),
        .rd_addr_q (rd_addr_q),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );
endmodule

// File: tb/tb_qdr_b2_sram.sv
module tb_qdr_b2_sram;
    localparam int AW    = 4;
    localparam int LANES = 2;
    localparam int LW    = 9;
    localparam int W     = LANES * LW;
    localparam int LOCK  = 1024;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_sel_n = 1'b1;
    logic             wr_sel_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     wdata = '0;
    logic [LANES-1:0] wr_lane_n = '1;
    logic [W-1:0]     rdata;
    logic             rdata_oe;
    logic             lock_busy;

    always #4 clk = ~clk;

    qdr_b2_sram dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_sel_n  (rd_sel_n),
        .wr_sel_n  (wr_sel_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_lane_n (wr_lane_n),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe),
        .lock_busy (lock_busy)
    );

    int    vectors = 0;
    int    fails = 0;
    int    n = 0;
    string tag = "R1";
    bit    done = 1'b0;

    logic [W-1:0] mm [2**(AW+1)];
    bit           ra_v = 1'b0, rb_v = 1'b0;
    logic [W-1:0] ra0 = '0, ra1 = '0, rb0 = '0, rb1 = '0;

    task automatic chk(input string t, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (slot %0d)", t, act, exp, n);
        end
    endtask

    // One clock slot, entered 2 ns before a rising edge.
    task automatic step(input bit rd, input bit wr, input logic [AW-1:0] ra,
                        input logic [AW-1:0] wa, input logic [W-1:0] w0,
                        input logic [W-1:0] w1, input logic [LANES-1:0] m0,
                        input logic [LANES-1:0] m1);
        bit           acc;
        bit           cv;
        logic [W-1:0] c0, c1;
        acc = (n >= LOCK);
        rd_sel_n  = !rd;
        wr_sel_n  = !wr;
        addr      = ra;
        wdata     = w0;
        wr_lane_n = m0;
        if (acc && wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (!m0[l]) mm[{wa, 1'b0}][l*LW +: LW] = w0[l*LW +: LW];
                if (!m1[l]) mm[{wa, 1'b1}][l*LW +: LW] = w1[l*LW +: LW];
            end
        end
        cv = acc && rd;
        c0 = cv ? mm[{ra, 1'b0}] : '0;
        c1 = cv ? mm[{ra, 1'b1}] : '0;
        #3;
        chk("R1", W'(lock_busy), W'(n + 1 < LOCK));
        chk(tag, W'(rdata_oe), W'(rb_v));
        chk(tag, rdata, rb_v ? rb1 : '0);
        #1;
        addr      = wa;
        wdata     = w1;
        wr_lane_n = m1;
        #3;
        chk(tag, W'(rdata_oe), W'(ra_v));
        chk(tag, rdata, ra_v ? ra0 : '0);
        #1;
        rb_v = ra_v; rb0 = ra0; rb1 = ra1;
        ra_v = cv;   ra0 = c0;  ra1 = c1;
        n++;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0, '0, '0, '1, '1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #10;
        chk("R1", W'(lock_busy), W'(1));
        chk("R9", W'(rdata_oe), W'(0));
        chk("R9", rdata, '0);
        #8;
        rst_n = 1'b1;

        // R2: requests during the lock period
        tag = "R2";
        for (int i = 0; i < LOCK; i++) begin
            step(1'($urandom), 1'($urandom), AW'($urandom), AW'($urandom),
                 W'($urandom), W'($urandom), LANES'($urandom), LANES'($urandom));
        end

        // R4: fill every address with full masks
        tag = "R4";
        for (int a = 0; a < 2**AW; a++) begin
            step(1'b0, 1'b1, '0, AW'(a), W'($urandom), W'($urandom), '0, '0);
        end
        idle();

        // R11: back-to-back readback
        tag = "R11";
        for (int a = 0; a < 2**AW; a++) begin
            step(1'b1, 1'b0, AW'(a), '0, '0, '0, '1, '1);
        end
        idle(); idle();

        // R5: per-word lane masks
        tag = "R5";
        step(1'b0, 1'b1, '0, 4'd3, W'($urandom), W'($urandom), 2'b01, 2'b10);
        step(1'b0, 1'b1, '0, 4'd4, W'($urandom), W'($urandom), 2'b11, 2'b00);
        step(1'b0, 1'b1, '0, 4'd5, W'($urandom), W'($urandom), 2'b10, 2'b11);
        step(1'b1, 1'b0, 4'd3, '0, '0, '0, '1, '1);
        step(1'b1, 1'b0, 4'd4, '0, '0, '0, '1, '1);
        step(1'b1, 1'b0, 4'd5, '0, '0, '0, '1, '1);
        idle(); idle();

        // R7: same-edge read and write to one address
        tag = "R7";
        step(1'b1, 1'b1, 4'd6, 4'd6, W'($urandom), W'($urandom), 2'b01, 2'b00);
        idle(); idle();
        step(1'b1, 1'b1, 4'd7, 4'd7, W'($urandom), W'($urandom), 2'b11, 2'b10);
        idle(); idle();

        // R6: same-edge read and write to different addresses
        tag = "R6";
        step(1'b1, 1'b1, 4'd8, 4'd9, W'($urandom), W'($urandom), 2'b00, 2'b00);
        step(1'b1, 1'b0, 4'd9, '0, '0, '0, '1, '1);
        idle(); idle();

        // R8: write then read on the next edge
        tag = "R8";
        step(1'b0, 1'b1, '0, 4'd10, W'($urandom), W'($urandom), 2'b00, 2'b01);
        step(1'b1, 1'b0, 4'd10, '0, '0, '0, '1, '1);
        idle(); idle();

        // R10: idle cycles keep contents
        tag = "R10";
        for (int i = 0; i < 5; i++) idle();
        for (int a = 0; a < 2**AW; a++) begin
            step(1'b1, 1'b0, AW'(a), '0, '0, '0, '1, '1);
        end
        idle(); idle();

        // R3: isolated reads
        tag = "R3";
        step(1'b1, 1'b0, 4'd2, '0, '0, '0, '1, '1);
        idle(); idle();
        step(1'b1, 1'b0, 4'd13, '0, '0, '0, '1, '1);
        idle(); idle();

        // R9: output released after an empty read slot
        tag = "R9";
        step(1'b1, 1'b0, 4'd1, '0, '0, '0, '1, '1);
        idle();
        step(1'b1, 1'b0, 4'd14, '0, '0, '0, '1, '1);
        idle(); idle(); idle();

        // R6: random concurrent traffic
        tag = "R6";
        for (int i = 0; i < 300; i++) begin
            step(1'($urandom), 1'($urandom), AW'($urandom), AW'($urandom),
                 W'($urandom), W'($urandom), LANES'($urandom), LANES'($urandom));
        end
        idle(); idle();

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung run expected completion");
            summary();
            $finish;
        end
    end
endmodule